// File: doc/BRIEF.md
# Quad Chrominance to RGB Reconstructor

This block turns one 2x2 quad of a compressed 4x4 texture block back into four RGB pixels in half-float format. The quad stores only two chrominance codes, red and blue. Each code is a 7-bit unsigned fraction of one. Green is not stored: the block recovers it as one minus red minus blue, and clamps it to zero when that difference would be negative. The red, blue and green fractions go to half float through combinational logic. Each of the three halves is then multiplied by the luminance of each of the four pixels. All four pixels share the same chrominance.

A luminance decoder upstream supplies the four half-float luminances of the quad in raster order, together with the quad's chrominance codes. It may present one quad per clock. By default the pipeline has two register stages, so four complete pixels leave the block on every clock. A parameter removes the middle register, which gives a one-stage variant.

Top module: `quad_rgb_rebuild`

## Requirements
- R1: While rst_n is low, out_valid is low and out_rgb is all zero. With the default configuration, a quad sampled with in_valid high appears with out_valid high exactly two rising edges later. A new quad can be accepted on every clock.
- R2: When red+blue < 128, the green fraction is (128 - red - blue)/128.
- R3: When red+blue >= 128, the green channel of all four pixels is 0x0000.
- R4: A chrominance code c is converted exactly to the half-float value c/128. With a luminance of 1.0 (0x3C00), a channel equals that half exactly; for example, code 64 gives 0x3800.
- R5: Each channel is the exact product of its chrominance fraction and the pixel's luminance, truncated toward zero to a 10-bit half-float mantissa. Sign bits are zero.
- R6: A product whose biased half exponent would be zero or below is flushed to 0x0000.
- R7: A luminance whose exponent field (bits 14:10) is zero, which covers zero and denormals, yields 0x0000 on all three channels of that pixel.
- R8: Pixel i, in raster order (0 top-left, 1 top-right, 2 bottom-left, 3 bottom-right), takes its luminance from in_luma[16i+15:16i]. It drives out_rgb[48i+47:48i], where red occupies bits 47:32 of that slice, green bits 31:16 and blue bits 15:0.
- R9: One chrominance pair applies to all four pixels of the quad.
- R10: No output channel exceeds its pixel's luminance when both are compared as unsigned 16-bit codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Quad inputs are valid this cycle |
| in_red | input | 7 | Red chrominance, fraction of one in 1/128 steps |
| in_blue | input | 7 | Blue chrominance, fraction of one in 1/128 steps |
| in_luma | input | 64 | Four half-float luminances, pixel i at bits 16i+15:16i |
| out_valid | output | 1 | out_rgb carries a reconstructed quad |
| out_rgb | output | 192 | Four RGB half-float pixels, pixel i at bits 48i+47:48i |

## Verification
The assertions assume that every luminance is non-negative and finite: its sign bit is zero and its exponent field is below 31. The bounding property R10 and the clean flush behaviour depend on this, because neither holds for negative codes or for infinities. The random stimulus therefore always builds luminances with a zero sign bit and an exponent drawn from 0 to 30. It leans on the low exponents so that flushing and the zero-exponent case occur often. Directed vectors cover sums of exactly one and above one, zero chrominance, and denormal luminances.

// File: rtl/quad_rgb_pkg.sv
package quad_rgb_pkg;
   typedef logic [15:0] half_t;
   localparam int HALF_MW   = 10;
   localparam int HALF_EW   = 5;
   localparam int HALF_BIAS = 15;
   localparam int HALF_EMAX = 31;
   localparam int NCHAN     = 3;
endpackage

// File: rtl/chroma_green.sv
module chroma_green #(
   parameter int CW = 7
) (
   input  logic [CW-1:0] red,
   input  logic [CW-1:0] blue,
   output logic [CW:0]   green
);
   localparam logic [CW:0] ONE = {1'b1, {CW{1'b0}}};

   logic [CW:0] total;

   assign total = {1'b0, red} + {1'b0, blue};
   assign green = (total >= ONE) ? '0 : (ONE - total);
endmodule

// File: rtl/fix_to_half.sv
module fix_to_half
   import quad_rgb_pkg::*;
#(
   parameter int CW = 7
) (
   input  logic [CW:0] frac,
   output half_t       h
);
   localparam int PW = (CW + 1 > 1) ? $clog2(CW + 1) : 1;

   logic [PW-1:0]      lead;
   logic [HALF_MW:0]   shifted;
   logic [HALF_EW:0]   expo;

   always_comb begin
      lead = '0;
      for (int i = 0; i <= CW; i++) begin
         if (frac[i]) lead = PW'(i);
      end
      shifted = (HALF_MW + 1)'(frac) << (HALF_MW - int'(lead));
      expo    = (HALF_EW + 1)'(int'(lead) + HALF_BIAS - CW);
      if (frac == '0) h = '0;
      else            h = {1'b0, expo[HALF_EW-1:0], shifted[HALF_MW-1:0]};
   end
endmodule

// File: rtl/half_mul_trunc.sv
module half_mul_trunc
   import quad_rgb_pkg::*;
(
   input  half_t a,
   input  half_t b,
   output half_t p
);
   localparam int PRW = 2 * (HALF_MW + 1);

   logic [PRW-1:0] prod;
   logic [HALF_EW-1:0] ea, eb;
   int e_res;

   always_comb begin
      ea    = a[HALF_MW +: HALF_EW];
      eb    = b[HALF_MW +: HALF_EW];
      prod  = PRW'({1'b1, a[HALF_MW-1:0]}) * PRW'({1'b1, b[HALF_MW-1:0]});
      e_res = int'(ea) + int'(eb) - HALF_BIAS + int'(prod[PRW-1]);
      if (ea == '0 || eb == '0 || e_res <= 0)
         p = '0;
      else if (e_res >= HALF_EMAX)
         p = {1'b0, {(HALF_EW-1){1'b1}}, 1'b0, {HALF_MW{1'b1}}};
      else if (prod[PRW-1])
         p = {1'b0, e_res[HALF_EW-1:0], prod[PRW-2 -: HALF_MW]};
      else
         p = {1'b0, e_res[HALF_EW-1:0], prod[PRW-3 -: HALF_MW]};
   end
endmodule

// File: rtl/quad_rgb_rebuild.sv
module quad_rgb_rebuild
   import quad_rgb_pkg::*;
#(
   parameter int CW      = 7,
   parameter int NPIX    = 4,
   parameter bit MID_REG = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [CW-1:0]          in_red,
   input  logic [CW-1:0]          in_blue,
   input  logic [NPIX*16-1:0]     in_luma,
   output logic                   out_valid,
   output logic [NPIX*48-1:0]     out_rgb
);
   localparam int LAT = MID_REG ? 2 : 1;
   localparam int LW  = NPIX * 16;
   localparam int PXW = NCHAN * 16;
   localparam logic [CW:0] ONE = {1'b1, {CW{1'b0}}};

   if (CW < 1 || CW > HALF_MW) begin : g_bad_cw
      $error("quad_rgb_rebuild: CW must lie in 1..10");
   end
   if (NPIX < 1) begin : g_bad_npix
      $error("quad_rgb_rebuild: NPIX must be at least 1");
   end

   // chrominance fractions, channel 0 red, 1 green, 2 blue
   logic [CW:0] frac [NCHAN];
   half_t       c_h  [NCHAN];
   logic [CW:0] green;

   chroma_green #(.CW(CW)) u_green (
      .red  (in_red),
      .blue (in_blue),
      .green(green)
   );

   assign frac[0] = {1'b0, in_red};
   assign frac[1] = green;
   assign frac[2] = {1'b0, in_blue};

   for (genvar ch = 0; ch < NCHAN; ch++) begin : g_conv
      fix_to_half #(.CW(CW)) u_conv (
         .frac(frac[ch]),
         .h   (c_h[ch])
      );
   end

   // optional register between conversion and multiply
   half_t           c_s [NCHAN];
   logic [LW-1:0]   luma_s;
   logic            v_s;

   if (MID_REG) begin : g_mid
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_s    <= 1'b0;
            luma_s <= '0;
            for (int k = 0; k < NCHAN; k++) c_s[k] <= '0;
         end else begin
            v_s    <= in_valid;
            luma_s <= in_luma;
            for (int k = 0; k < NCHAN; k++) c_s[k] <= c_h[k];
         end
      end
   end else begin : g_flat
      always_comb begin
         v_s    = in_valid;
         luma_s = in_luma;
         for (int k = 0; k < NCHAN; k++) c_s[k] = c_h[k];
      end
   end

   half_t prod [NPIX*NCHAN];

   for (genvar px = 0; px < NPIX; px++) begin : g_pix
      for (genvar ch = 0; ch < NCHAN; ch++) begin : g_ch
         half_mul_trunc u_mul (
            .a(c_s[ch]),
            .b(luma_s[px*16 +: 16]),
            .p(prod[px*NCHAN + ch])
         );
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_rgb   <= '0;
      end else begin
         out_valid <= v_s;
         for (int px = 0; px < NPIX; px++) begin
            for (int ch = 0; ch < NCHAN; ch++) begin
               out_rgb[px*PXW + 16*(NCHAN-1-ch) +: 16] <= prod[px*NCHAN + ch];
            end
         end
      end
   end

   // R1: output valid only when a quad entered LAT edges earlier
   a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid, LAT));

   for (genvar px = 0; px < NPIX; px++) begin : g_chk
      // R7: zero-exponent luminance clears the whole pixel
      a_r7_zero_luma: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && $past(in_luma[px*16 + HALF_MW +: HALF_EW] == '0, LAT))
         |-> (out_rgb[px*PXW +: PXW] == '0));
      // R3: green is zero when red plus blue reaches one
      a_r3_green_clamp: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && $past(({1'b0, in_red} + {1'b0, in_blue}) >= ONE, LAT))
         |-> (out_rgb[px*PXW + 16 +: 16] == '0));
      for (genvar ch = 0; ch < NCHAN; ch++) begin : g_bound
         // R10: a channel never exceeds its pixel luminance
         a_r10_bounded: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_rgb[px*PXW + 16*ch +: 16] <= $past(in_luma[px*16 +: 16], LAT)));
      end
   end
endmodule

// File: tb/quad_rgb_rebuild_bench.sv
module quad_rgb_rebuild_bench;
   localparam int CLK_PERIOD = 10;
   localparam int CW   = 7;
   localparam int NPIX = 4;
   localparam int LAT  = 2;
   localparam int NVEC = 220;
   localparam int NDIR = 8;

   logic                 clk = 1'b0;
   logic                 rst_n;
   logic                 in_valid;
   logic [CW-1:0]        in_red, in_blue;
   logic [NPIX*16-1:0]   in_luma;
   logic                 out_valid;
   logic [NPIX*48-1:0]   out_rgb;

   int checks   = 0;
   int failures = 0;

   logic [CW-1:0]      vr [NVEC];
   logic [CW-1:0]      vb [NVEC];
   logic [NPIX*16-1:0] vl [NVEC];
   string              vt [NVEC];

   quad_rgb_rebuild u_quad_rgb_rebuild (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .in_red(in_red), .in_blue(in_blue), .in_luma(in_luma),
      .out_valid(out_valid), .out_rgb(out_rgb)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // expected channel: exact c/128 * luma, truncated, flushed below normal range
   function automatic logic [15:0] exp_ch(int c, logic [15:0] l);
      int e, m, prod, k, be, mant;
      e = int'(l[14:10]);
      m = int'(l[9:0]);
      if (e == 0 || c == 0) return 16'h0000;
      prod = c * (1024 + m);
      k = 0;
      for (int i = 0; i < 31; i++) if ((prod >> i) & 1) k = i;
      be = k + e - 17;
      if (be <= 0) return 16'h0000;
      if (k >= 10) mant = (prod >> (k - 10)) & 32'h3FF;
      else         mant = (prod << (10 - k)) & 32'h3FF;
      return {1'b0, be[4:0], mant[9:0]};
   endfunction

   function automatic logic [47:0] exp_pix(int r, int b, logic [15:0] l);
      int g;
      g = (r + b >= 128) ? 0 : 128 - r - b;
      return {exp_ch(r, l), exp_ch(g, l), exp_ch(b, l)};
   endfunction

   task automatic check(string tag, logic [191:0] act, logic [191:0] expv);
      checks++;
      if (act !== expv) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   function automatic logic [15:0] rand_luma();
      int e;
      e = ($urandom % 3 == 0) ? int'($urandom % 4) : int'($urandom % 31);
      return {1'b0, 5'(e), 10'($urandom)};
   endfunction

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      failures++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      finish_run();
   end

   initial begin
      logic [191:0] expv;
      void'($urandom(32'd20160408));
      // directed vectors
      vr[0] = 64;  vb[0] = 32;  vl[0] = {4{16'h3C00}};                 vt[0] = "R4/R2";
      vr[1] = 100; vb[1] = 50;  vl[1] = {16'h4A10, 16'h3C00, 16'h5000, 16'h2E55}; vt[1] = "R3 sum above one";
      vr[2] = 64;  vb[2] = 64;  vl[2] = {4{16'h4400}};                 vt[2] = "R3 sum exactly one";
      vr[3] = 90;  vb[3] = 17;  vl[3] = {16'h3C00, 16'h4500, 16'h0123, 16'h0000}; vt[3] = "R7 zero/denormal luma";
      vr[4] = 1;   vb[4] = 3;   vl[4] = {16'h0400, 16'h07FF, 16'h0C00, 16'h1000}; vt[4] = "R6 flush";
      vr[5] = 0;   vb[5] = 0;   vl[5] = {16'h3C00, 16'h7BFF, 16'h1234, 16'h5555}; vt[5] = "R2 green one";
      vr[6] = 127; vb[6] = 0;   vl[6] = {16'h1111, 16'h2222, 16'h3333, 16'h4444}; vt[6] = "R8/R9 raster";
      vr[7] = 5;   vb[7] = 120; vl[7] = {16'h6000, 16'h3800, 16'h0800, 16'h7000}; vt[7] = "R5/R1 back-to-back";
      for (int i = NDIR; i < NVEC; i++) begin
         vr[i] = 7'($urandom);
         vb[i] = ($urandom % 2 == 0) ? 7'($urandom % 64) : 7'($urandom);
         vl[i] = {rand_luma(), rand_luma(), rand_luma(), rand_luma()};
         vt[i] = "R5/R9 random";
      end

      rst_n = 1'b0; in_valid = 1'b0; in_red = '0; in_blue = '0; in_luma = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      checks++;
      if (out_valid !== 1'b0) begin
         failures++;
         $display("FAIL R1 reset valid actual=%b expected=0", out_valid);
      end
      check("R1 reset data", out_rgb, '0);
      rst_n = 1'b1;

      for (int j = 0; j < NVEC + LAT; j++) begin
         @(negedge clk);
         if (j >= LAT) begin
            int v;
            v = j - LAT;
            checks++;
            if (out_valid !== 1'b1) begin
               failures++;
               $display("FAIL R1 valid vec %0d actual=%b expected=1", v, out_valid);
            end
            for (int p = 0; p < NPIX; p++)
               expv[p*48 +: 48] = exp_pix(int'(vr[v]), int'(vb[v]), vl[v][p*16 +: 16]);
            check($sformatf("%s R8 vec %0d", vt[v], v), out_rgb, expv);
            if (v >= NDIR) begin
               // R10: channel never above luminance
               logic bad;
               bad = 1'b0;
               for (int p = 0; p < NPIX; p++)
                  for (int c = 0; c < 3; c++)
                     if (out_rgb[p*48 + c*16 +: 16] > vl[v][p*16 +: 16]) bad = 1'b1;
               checks++;
               if (bad) begin
                  failures++;
                  $display("FAIL R10 vec %0d actual=%h expected<=%h", v, out_rgb, vl[v]);
               end
            end
         end
         if (j < NVEC) begin
            in_valid = 1'b1; in_red = vr[j]; in_blue = vb[j]; in_luma = vl[j];
         end else begin
            in_valid = 1'b0; in_red = '0; in_blue = '0; in_luma = '0;
         end
      end
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
         failures++;
         $display("FAIL R1 idle valid actual=%b expected=0", out_valid);
      end
      finish_run();
   end
endmodule